// File: doc/BRIEF.md
# Mixed-Policy Control and Status Register Bank

This block is a bank of 32-bit registers on a simple address, read-strobe and write-strobe bus. A parameter assigns every bit of every register one access policy. The policies are plain storage, live hardware status, write-only control, write-one-to-clear, clear-on-read, self-clearing action trigger, latched high event, latched low event, or reserved. The hardware side drives one event or status input per bit and one done strobe per bit. It receives one control output per bit, which carries the stored value of each storage, write-only and trigger bit.

Bus accesses are always whole 32-bit words. Software that wants to change part of a register reads it, modifies the value and writes it back. The address is a byte offset. With the default `NREG` of 4, registers sit at 0x00 and 0x04, and further registers start at 0x20 with a 4-byte stride. Offsets 0x08 to 0x1F form a reserved window. The read data is combinational while `rd_en` is high. The side effects of a read take place on the clock edge that ends the read cycle.

Top module: `csr_attr_bank`

## Requirements
- R1: A storage bit returns the last value written since reset. Its value is driven on `ctl_out`. In the default map these are bits 7:0 of 0x00 (reset value 0xA5) and bits 15:0 of 0x24.
- R2: A status bit reads the live value of its `hw_in` bit, and writes do not affect it. In the default map these are bits 7:0 of 0x04 and bits 31:16 of 0x24.
- R3: A write-only bit takes the written value onto `ctl_out` and always reads as 0. In the default map these are bits 15:8 of 0x00.
- R4: A write-one-to-clear bit (bits 15:8 of 0x04) is set by a high `hw_in`. Writing 1 clears it and writing 0 leaves it unchanged.
- R5: A clear-on-read bit (bits 23:16 of 0x04) is set by a high `hw_in`. It reads its held value and returns to 0 on the edge that ends the read. Writes do not affect it.
- R6: A trigger bit (bits 23:16 of 0x00) goes to 1 when written with 1 and stays at 1 on `ctl_out` and on reads until its `hw_done` bit pulses. Writing 0 has no effect on it.
- R7: A latch-high bit (bits 7:0 of 0x20) goes to 1 when its `hw_in` is high. After a read it returns to 0 unless `hw_in` is still high.
- R8: A latch-low bit (bits 15:8 of 0x20, reset value 1) goes to 0 when its `hw_in` is low and holds 0 until read. The edge that ends a read loads the live `hw_in`. Writes do not affect it.
- R9: Reads of offsets 0x08 to 0x1F return 0x0000FFFF. Writes to that window change no register. Other unmapped offsets read as 0.
- R10: Reserved bits (bits 31:24 of 0x00 and 0x04, bits 31:16 of 0x20) read as 0 and ignore writes.
- R11: A hardware set that coincides with a write-one clear or a clearing read wins, and the bit stays 1.
- R12: A synchronous active-high `rst` returns every register to its parameterised default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; read side effects occur at the next edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high |
| hw_in | input | NREG*32 | Per-bit event or live status from hardware |
| hw_done | input | NREG*32 | Per-bit action-complete strobe for trigger bits |
| ctl_out | output | NREG*32 | Per-bit stored control value to hardware |

## Verification
Two things can reach the same sticky bit in a single cycle: a hardware set from `hw_in`, and a bus clear, which is either a write of 1 or a read. The bench raises the `hw_in` pulse on the same falling edge that asserts the clearing strobe, so both are sampled at the same rising edge. It then rereads the bit. The bit must still be 1 after the collision, and it must return to 0 only after a later read that has no competing event.

// File: rtl/csr_attr_bank.sv
module csr_attr_bank #(
  parameter int NREG = 4,
  parameter logic [NREG*32*4-1:0] ATTR = {
    {{16{4'd2}}, {16{4'd1}}},
    {{16{4'd0}}, {8{4'd8}}, {8{4'd7}}},
    {{8{4'd0}}, {8{4'd5}}, {8{4'd4}}, {8{4'd2}}},
    {{8{4'd0}}, {8{4'd6}}, {8{4'd3}}, {8{4'd1}}}},
  parameter logic [NREG*32-1:0] RST = {32'h0, 32'h0000_FF00, 32'h0, 32'h0000_00A5}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [7:0]           addr,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  input  logic [NREG*32-1:0]   hw_in,
  input  logic [NREG*32-1:0]   hw_done,
  output logic [NREG*32-1:0]   ctl_out
);
  localparam int NB = NREG * 32;
  localparam logic [3:0] K_RSV = 4'd0, K_RW = 4'd1, K_RO = 4'd2, K_WO = 4'd3,
                         K_W1C = 4'd4, K_RC = 4'd5, K_SC = 4'd6, K_LH = 4'd7, K_LL = 4'd8;

  function automatic logic [NB-1:0] kind_mask(input logic [3:0] k);
    logic [NB-1:0] m;
    for (int i = 0; i < NB; i++) m[i] = (ATTR[i*4 +: 4] == k);
    return m;
  endfunction

  localparam logic [NB-1:0] M_RW  = kind_mask(K_RW);
  localparam logic [NB-1:0] M_WO  = kind_mask(K_WO);
  localparam logic [NB-1:0] M_SC  = kind_mask(K_SC);
  localparam logic [NB-1:0] M_LL  = kind_mask(K_LL);
  localparam logic [NB-1:0] M_SET = kind_mask(K_W1C) | kind_mask(K_RC) | kind_mask(K_LH);

  logic [NREG-1:0] sel;
  logic            rsvd;
  logic [NB-1:0]   q, rv, w1;

  assign rsvd = (addr >= 8'h08) && (addr <= 8'h1F);

  always_comb begin
    for (int r = 0; r < NREG; r++)
      sel[r] = (r < 2) ? (addr == 8'(4*r)) : (addr == 8'(32 + 4*(r-2)));
  end

  for (genvar g = 0; g < NB; g++) begin : g_bit
    localparam int R = g / 32;
    localparam int B = g % 32;
    localparam logic [3:0] K = ATTR[g*4 +: 4];
    logic wh, rh, nxt, qb;
    assign wh = wr_en & sel[R];
    assign rh = rd_en & sel[R];
    assign w1[g] = wh & wdata[B];

    always_comb begin
      case (K)
        K_RW, K_WO: nxt = wh ? wdata[B] : qb;
        K_W1C:      nxt = (qb & ~w1[g]) | hw_in[g];
        K_RC, K_LH: nxt = (rh ? 1'b0 : qb) | hw_in[g];
        K_SC:       nxt = (qb & ~hw_done[g]) | w1[g];
        K_LL:       nxt = rh ? hw_in[g] : (qb & hw_in[g]);
        default:    nxt = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) qb <= (K == K_RSV || K == K_RO) ? 1'b0 : RST[g];
      else     qb <= nxt;
    end

    assign q[g]  = qb;
    assign rv[g] = (K == K_RO) ? hw_in[g] :
                   (K == K_RSV || K == K_WO) ? 1'b0 : qb;
  end

  assign ctl_out = q & (M_RW | M_WO | M_SC);

  always_comb begin
    rdata = 32'h0;
    if (rsvd) rdata = 32'h0000_FFFF;
    else
      for (int r = 0; r < NREG; r++)
        if (sel[r]) rdata = rv[r*32 +: 32];
  end

  // R1: storage bits only move on a write to their register
  a_r1_rw_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q & M_RW));
  // R4, R5, R7, R11: a hardware set is never lost, whatever the bus does
  a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q & $past(hw_in) & M_SET) == ($past(hw_in) & M_SET)));
  // R6: a trigger bit rises only on a written 1
  a_r6_sc_rise: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q & ~$past(q) & M_SC & ~$past(w1)) == '0));
  // R6: done without a new write drops the trigger
  a_r6_sc_done: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q & M_SC & $past(hw_done & ~w1)) == '0));
  // R8: a low status always leaves its latch-low bit at 0
  a_r8_ll_drop: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q & M_LL & ~$past(hw_in)) == '0));
  // R9: the reserved window returns the fixed pattern
  a_r9_window: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr >= 8'h08 && addr <= 8'h1F) |-> (rdata == 32'h0000_FFFF));
endmodule

// File: tb/csr_attr_bank_test.sv
module csr_attr_bank_test;
  logic         clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [7:0]   addr = 0;
  logic [31:0]  wdata = 0, rdata;
  logic [127:0] hw_in, hw_done = 0, ctl_out, hw_base = 0;
  int total = 0, bad = 0;
  bit done = 0;

  csr_attr_bank uut (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .hw_in(hw_in), .hw_done(hw_done), .ctl_out(ctl_out));

  always #5 clk = ~clk;

  // {write, addr, wdata, expected read}
  localparam int NV = 20;
  localparam logic [72:0] VEC [0:NV-1] = '{
    {1'b0, 8'h00, 32'h0, 32'h0000_00A5},          // R12 R1 reset value
    {1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h00, 32'h0, 32'h00FF_00FF},          // R1 R3 R6 R10
    {1'b1, 8'h00, 32'h0000_003C, 32'h0},
    {1'b0, 8'h00, 32'h0, 32'h00FF_003C},          // R6 write 0 keeps trigger
    {1'b0, 8'h04, 32'h0, 32'h0},
    {1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h04, 32'h0, 32'h0},                  // R2 R4 R5 R10 writes set nothing
    {1'b0, 8'h08, 32'h0, 32'h0000_FFFF},          // R9
    {1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h1C, 32'h0, 32'h0000_FFFF},          // R9
    {1'b0, 8'h00, 32'h0, 32'h00FF_003C},          // R9 window write discarded
    {1'b0, 8'h20, 32'h0, 32'h0000_FF00},          // R8 reset high
    {1'b1, 8'h20, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h20, 32'h0, 32'h0000_FF00},          // R7 R8 writes ignored
    {1'b1, 8'h24, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h24, 32'h0, 32'h0000_FFFF},          // R1 R2
    {1'b1, 8'h24, 32'h1234_5678, 32'h0},
    {1'b0, 8'h24, 32'h0, 32'h0000_5678},          // R1 R2
    {1'b0, 8'h28, 32'h0, 32'h0}                   // R9 unmapped
  };

  task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d,
                     input logic [127:0] pulse, input logic [127:0] drop,
                     input logic [31:0] exp, input string tag);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    hw_in = (hw_base | pulse) & ~drop;
    #2;
    if (r) chk({96'h0, rdata}, {96'h0, exp}, tag);
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; hw_in = hw_base;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1, 0, a, d, '0, '0, 32'h0, "wr");
  endtask
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    cyc(0, 1, a, 32'h0, '0, '0, exp, tag);
  endtask
  task automatic idle(input logic [127:0] pulse, input logic [127:0] drop);
    cyc(0, 0, 8'h0, 32'h0, pulse, drop, 32'h0, "idle");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    hw_base[79:72] = 8'hFF;
    hw_in = hw_base;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    chk(ctl_out, {96'h0, 32'h0000_00A5}, "R12 ctl_out after reset");

    for (int i = 0; i < NV; i++)
      cyc(VEC[i][72], !VEC[i][72], VEC[i][71:64], VEC[i][63:32], '0, '0, VEC[i][31:0], "R1-table");

    chk(ctl_out[31:0], 32'h00FF_003C, "R1 R6 ctl_out");
    wr(8'h00, 32'h0000_A500);
    chk(ctl_out[15:8], 8'hA5, "R3 write-only drives ctl_out");
    rd(8'h00, 32'h00FF_0000, "R3 write-only reads zero");

    @(negedge clk); hw_done[19] = 1; @(posedge clk); #1 hw_done = 0;
    chk(ctl_out[23:16], 8'hF7, "R6 done clears trigger");
    rd(8'h00, 32'h00F7_0000, "R6 read after done");
    wr(8'h00, 32'h0008_0000);
    chk(ctl_out[23:16], 8'hFF, "R6 retrigger");

    hw_base[39:32] = 8'h5A;
    rd(8'h04, 32'h0000_005A, "R2 live status");
    wr(8'h04, 32'h0000_0000);
    rd(8'h04, 32'h0000_005A, "R2 write ignored");
    hw_base[39:32] = 8'h00;

    idle(128'hFF << 40, '0);
    rd(8'h04, 32'h0000_FF00, "R4 set by event");
    wr(8'h04, 32'h0000_0F00);
    rd(8'h04, 32'h0000_F000, "R4 write one clears");
    wr(8'h04, 32'h0000_0000);
    rd(8'h04, 32'h0000_F000, "R4 write zero keeps");
    cyc(1, 0, 8'h04, 32'h0000_1000, 128'h1 << 44, '0, 32'h0, "wr");
    rd(8'h04, 32'h0000_F000, "R11 event beats write clear");
    wr(8'h04, 32'h0000_F000);
    rd(8'h04, 32'h0, "R4 all cleared");

    idle(128'h81 << 48, '0);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0081_0000, "R5 held after write");
    rd(8'h04, 32'h0, "R5 cleared by read");
    cyc(0, 1, 8'h04, 32'h0, 128'h1 << 48, '0, 32'h0, "R5 read during event");
    rd(8'h04, 32'h0001_0000, "R11 event beats read clear");
    rd(8'h04, 32'h0, "R5 cleared afterwards");

    idle(128'h1 << 64, '0);
    rd(8'h20, 32'h0000_FF01, "R7 latched pulse");
    rd(8'h20, 32'h0000_FF00, "R7 released by read");
    hw_base[65] = 1;
    idle('0, '0);
    rd(8'h20, 32'h0000_FF02, "R7 active");
    rd(8'h20, 32'h0000_FF02, "R7 still active after read");
    hw_base[65] = 0;
    rd(8'h20, 32'h0000_FF02, "R7 held until read");
    rd(8'h20, 32'h0000_FF00, "R7 released");

    idle('0, 128'h1 << 72);
    rd(8'h20, 32'h0000_FE00, "R8 latched low");
    rd(8'h20, 32'h0000_FF00, "R8 live after read");
    hw_base[73] = 0;
    idle('0, '0);
    rd(8'h20, 32'h0000_FD00, "R8 low");
    hw_base[73] = 1;
    rd(8'h20, 32'h0000_FD00, "R8 held low until read");
    rd(8'h20, 32'h0000_FF00, "R8 live again");

    wr(8'h00, 32'hFFFF_FFFF);
    @(negedge clk); rst = 1; @(posedge clk); #1 rst = 0;
    chk(ctl_out, {96'h0, 32'h0000_00A5}, "R12 ctl_out after mid-run reset");
    rd(8'h00, 32'h0000_00A5, "R12 reg0 default");
    rd(8'h20, 32'h0000_FF00, "R12 reg2 default");

    finish_run();
  end
endmodule